// File: doc/BRIEF.md
# Row-Buffered DRAM Behavioural Model

This block is a synthesizable model of a small dynamic memory device, intended as the target that a DRAM controller under test talks to. The storage is a grid of rows, each holding a fixed number of column cells. One address bus carries the row number and then the column number. Active-low row strobe, column strobe, write enable and output enable inputs control each access. The bidirectional data pin is modelled as a separate input bus, an output bus and an output-drive flag.

All strobes are sampled on the system clock, and a strobe edge is a change between two samples. When the row strobe falls, the addressed row is moved into a row buffer. Because reading the row destroys the cell charge, the row's slots in the array are cleared at that point. Each column strobe then reads or writes one cell of the buffer. When the row strobe rises, the buffer is written back to the array. A column strobe that arrives while no row is open is ignored and raises a one-cycle error flag, which a testbench can watch.

Top module: `dram_rowbuf`

## Requirements
- R1: After reset, every cell reads as zero, and dOutEn and casErr are low.
- R2: If rasN is low at a clock edge and was high at the previous edge, addrIn is latched as the row number and that row's cells are copied into the row buffer, so later reads in this row return that row's contents.
- R3: If casN is low at a clock edge, was high at the previous edge, and rasN was already low at the previous edge, addrIn is latched as the column number. From the following cycle, dOut shows that buffered cell while oeN and casN stay low.
- R4: dOutEn is low whenever oeN or casN is high. When oeN is lowered after the column strobe (a late read), dOutEn rises in the same cycle and dOut shows the selected cell.
- R5: While rasN stays low, further column strobes with new addresses access other cells of the same buffered row, without a new row activation.
- R6: If weN is low at an accepted column-strobe edge, dIn is written into the buffer at the latched column, and a later read in the same row returns it.
- R7: When rasN rises, the buffer is written back to the latched row. Because opening a row clears it in the array, data written in a row survives closing it, opening another row, and reopening it.
- R8: A column-strobe fall with no row open has no effect on storage and leaves dOutEn low. casErr goes high for exactly the one cycle after that edge.
- R9: Row count, column count and data width are parameters, with defaults of 4 rows, 4 columns and 8 bits. The address width is the larger of the row-index and column-index widths, which is 2 bits at the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset, clears the array |
| addrIn | input | ADDR_W | Multiplexed row/column address |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low, sampled at column strobe |
| oeN | input | 1 | Output enable, active low |
| dIn | input | DATA_W | Write data |
| dOut | output | DATA_W | Read data, meaningful while dOutEn is high |
| dOutEn | output | 1 | High when the data pin would be driven |
| casErr | output | 1 | One-cycle pulse for a column strobe with no open row |

## Verification
The bench goes after write-back across row switches. A model that clears the row on activation but never restores it loses every value on reopen, and one that restores to the wrong row corrupts a neighbour. It checks that page-mode reads within one open row return different columns, which fails if the column latch is not updated per strobe. It checks late reads and writes with output disabled, where a wrong enable would drive data too early. It also checks an orphan column strobe, where a careless design writes into the stale buffer or misses the error pulse.

// File: rtl/dram_pkg.sv
package dram_pkg;
  // strobes passed from control to datapath, one cycle wide except drive
  typedef struct packed {
    logic loadRow;   // open row: copy array row into buffer
    logic storeRow;  // close row: write buffer back to array
    logic selCol;    // accepted column strobe: latch column
    logic writeCol;  // accepted column strobe with write enable
    logic drive;     // a column access is active
  } dramStrb_t;
endpackage

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rasN,
  input  logic      casN,
  input  logic      weN,
  output dramStrb_t strb,
  output logic      casErr
);
  logic rasPrev, casPrev, casValid;
  logic rasFall, rasRise, casFall, casGood;

  always_comb begin
    rasFall = rasPrev & ~rasN;
    rasRise = ~rasPrev & rasN;
    casFall = casPrev & ~casN;
    // a row counts as open only once rasN was low at the previous edge
    casGood = casFall & ~rasPrev & ~rasN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasPrev  <= 1'b1;
      casPrev  <= 1'b1;
      casValid <= 1'b0;
      casErr   <= 1'b0;
    end else begin
      rasPrev <= rasN;
      casPrev <= casN;
      casErr  <= casFall & ~casGood;
      if (rasN || casN)  casValid <= 1'b0;
      else if (casGood)  casValid <= 1'b1;
    end
  end

  always_comb begin
    strb.loadRow  = rasFall;
    strb.storeRow = rasRise;
    strb.selCol   = casGood;
    strb.writeCol = casGood & ~weN;
    strb.drive    = casValid;
  end

  // R3: an active access implies both strobes were low at the edge that kept it
  assert_access_needs_strobes_R3: assert property (@(posedge clk) disable iff (!rstN)
    casValid |-> $past(!rasN && !casN));

  // R8: an orphan column strobe never starts an access
  assert_err_no_access_R8: assert property (@(posedge clk) disable iff (!rstN)
    casErr |-> !casValid);

  // R8: the error flag is a single-cycle pulse
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    casErr |=> !casErr);
endmodule

// File: rtl/dram_datapath.sv
module dram_datapath
  import dram_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dramStrb_t         strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dIn,
  input  logic              oeN,
  input  logic              casN,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn
);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;

  typedef logic [COLS-1:0][DATA_W-1:0] rowWord_t;

  rowWord_t         cellArr [ROWS];
  rowWord_t         rowBuf;
  logic [ROW_W-1:0] rowSel, addrRow;
  logic [COL_W-1:0] colSel, addrCol;

  assign addrRow = addrIn[ROW_W-1:0];
  assign addrCol = addrIn[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ROWS; i++) cellArr[i] <= '0;
      rowBuf <= '0;
      rowSel <= '0;
      colSel <= '0;
    end else begin
      if (strb.loadRow) begin
        rowSel           <= addrRow;
        rowBuf           <= cellArr[addrRow];
        cellArr[addrRow] <= '0;          // sensing drains the cells
      end
      if (strb.storeRow) cellArr[rowSel] <= rowBuf;
      if (strb.selCol)   colSel <= addrCol;
      if (strb.writeCol) rowBuf[addrCol] <= dIn;
    end
  end

  assign dOut   = rowBuf[colSel];
  assign dOutEn = strb.drive & ~oeN & ~casN;

  // R2: activation copies the addressed array row into the buffer
  assert_row_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRow |=> rowBuf == $past(cellArr[addrRow]));

  // R7: activation leaves the array row drained until write-back
  assert_row_drained_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRow |=> cellArr[rowSel] == '0);

  // R7: closing the row restores the buffer into the latched row
  assert_writeback_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeRow |=> cellArr[$past(rowSel)] == $past(rowBuf));

  // R6: an accepted write lands in the buffer at the strobed column
  assert_col_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeCol |=> rowBuf[$past(addrCol)] == $past(dIn));
endmodule

// File: rtl/dram_rowbuf.sv
module dram_rowbuf
  import dram_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int DATA_W = 8,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn,
  output logic              casErr
);
  dramStrb_t strb;

  dram_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN),
    .strb(strb), .casErr(casErr)
  );

  dram_datapath #(
    .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn), .dIn(dIn),
    .oeN(oeN), .casN(casN), .dOut(dOut), .dOutEn(dOutEn)
  );

  // R4: the pin is never driven without a row open
  assert_drive_in_row_R4: assert property (@(posedge clk) disable iff (!rstN)
    dOutEn |-> !rasN);
endmodule

// File: tb/dram_rowbuf_tb_top.sv
module dram_rowbuf_tb_top;
  localparam int ROWS = 4, COLS = 4, DW = 8, AW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          rasN = 1'b1, casN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic          dOutEn, casErr;

  int testsRun = 0, testsFailed = 0;
  logic [DW-1:0] refMem [ROWS][COLS];
  int curRow = 0;
  logic [DW-1:0] expQ[$];
  string         tagQ[$];
  logic          prevEn = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  dram_rowbuf #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .rasN(rasN), .casN(casN),
    .weN(weN), .oeN(oeN), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn), .casErr(casErr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  // monitor: compare each new drive window against the scoreboard
  always @(negedge clk) begin
    if (dOutEn && !prevEn) begin
      if (expQ.size() == 0) chk("R4 unexpected drive", 32'(dOutEn), 32'd0);
      else begin
        logic [DW-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, 32'(dOut), 32'(e));
      end
    end
    prevEn = dOutEn;
  end

  task automatic openRow(int r);
    addrIn = AW'(r); rasN = 1'b0; curRow = r;
    step(); step();
  endtask

  task automatic closeRow();
    rasN = 1'b1; step(); step();
  endtask

  task automatic readCol(int c, string tag);
    addrIn = AW'(c); weN = 1'b1; oeN = 1'b0; casN = 1'b0;
    expQ.push_back(refMem[curRow][c]); tagQ.push_back(tag);
    step(); step();
    casN = 1'b1; oeN = 1'b1; step();
  endtask

  task automatic writeCol(int c, logic [DW-1:0] d);
    addrIn = AW'(c); dIn = d; weN = 1'b0; oeN = 1'b1; casN = 1'b0;
    refMem[curRow][c] = d;
    step();
    chk("R4 no drive while oeN high", 32'(dOutEn), 32'd0);
    casN = 1'b1; weN = 1'b1; step();
  endtask

  initial begin
    #(8 * 100000);
    testsRun++; testsFailed++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) refMem[r][c] = '0;
    repeat (3) step();
    rstN = 1'b1; step();
    chk("R1 dOutEn after reset", 32'(dOutEn), 32'd0);
    chk("R1 casErr after reset", 32'(casErr), 32'd0);

    // R1/R9: whole default geometry reads zero
    for (int r = 0; r < ROWS; r++) begin
      openRow(r);
      for (int c = 0; c < COLS; c++) readCol(c, "R1");
      closeRow();
    end

    // R6 writes, R5 page-mode reads in one open row
    openRow(2);
    writeCol(0, 8'hA5);
    writeCol(3, 8'h3C);
    readCol(3, "R6");
    readCol(0, "R5");
    readCol(1, "R5");
    closeRow();

    // R7: data survives close, another row, reopen
    openRow(1); writeCol(1, 8'h77); closeRow();
    openRow(3); writeCol(1, 8'h11); writeCol(2, 8'hE2); closeRow();
    openRow(1); readCol(1, "R7"); closeRow();
    openRow(2); readCol(0, "R7"); readCol(3, "R7"); closeRow();

    // R2: row selection keeps rows distinct
    openRow(3); readCol(2, "R2"); readCol(1, "R2"); closeRow();

    // R4: late read, drive follows oeN while casN stays low
    openRow(2);
    addrIn = 2'd3; weN = 1'b1; oeN = 1'b1; casN = 1'b0;
    step();
    chk("R4 no drive before oeN", 32'(dOutEn), 32'd0);
    expQ.push_back(refMem[2][3]); tagQ.push_back("R4 late read");
    oeN = 1'b0; step();
    oeN = 1'b1; #1;
    chk("R4 drive drops with oeN", 32'(dOutEn), 32'd0);
    casN = 1'b1; step();
    closeRow();

    // R8: orphan column strobe with write enable
    addrIn = 2'd1; dIn = 8'hFF; weN = 1'b0; casN = 1'b0;
    step();
    chk("R8 casErr pulse", 32'(casErr), 32'd1);
    chk("R8 no drive", 32'(dOutEn), 32'd0);
    step();
    chk("R8 casErr one cycle", 32'(casErr), 32'd0);
    casN = 1'b1; weN = 1'b1; step();
    openRow(3); readCol(1, "R8 no write"); closeRow();
    openRow(0); readCol(1, "R8 no write"); closeRow();

    step();
    chk("R3 scoreboard drained", 32'(expQ.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule